// File: doc/BRIEF.md
# USB Endpoint Control and Status Register

This block holds the per-endpoint control and status state of a full-speed USB device controller. Firmware reaches it through a register write port and read-back outputs clocked by the peripheral clock. The packet engine reaches it through a handful of event inputs and state outputs clocked by the USB clock. Two status flags are kept. The transmit-done flag reports that the host acknowledged an IN transaction. The bank-0-full flag reports that a received packet sits in receive bank 0 and that its byte count is readable. A transmit-ready control bit starts an IN transaction.

A status flag is set only by an event from the USB side. Firmware clears a flag by writing zero to its position. Writing one leaves the flag alone, so a read-modify-write that puts ones in the flag positions is safe. Each flag raises the interrupt while it is set and its enable bit is on.

Every accepted write is carried into the USB clock domain by a toggle handshake. The busy output stays high until the USB side has applied the update and acknowledged it. Busy is also held for a minimum time, and that minimum is longer for updates that hand buffer ownership across the two domains. Firmware waits for busy to fall before it touches the packet buffer or writes again.

Top module: `usb_ep_csr`

## Requirements
- R1: After reset, every output is 0: both flags, the transmit-ready bit, the count, the interrupt, busy, and both USB-side state outputs.
- R2: An accepted write with 0 in bit 0 clears the transmit-done flag at the next clock. An accepted write with 0 in bit 1 clears the bank-0-full flag at the next clock.
- R3: An accepted write with 1 in bit 0 or bit 1 leaves the corresponding flag unchanged.
- R4: A one-cycle pulse on u_txack_i clears u_txpktrdy_o at the next USB clock. It also sets txcomp_o and clears txpktrdy_o within 8 peripheral clocks.
- R5: A one-cycle pulse on u_rxpkt_i sets u_bk0_full_o at the next USB clock. Within 8 peripheral clocks it sets rxbk0_o, and rxcnt_o then shows the u_rxcnt_i value captured with the pulse. rxcnt_o reads 0 while rxbk0_o is 0.
- R6: When a flag set from the USB side and a clearing write land on the same peripheral clock, the flag ends up set.
- R7: irq_o is 1 exactly when, one peripheral clock earlier, transmit-done was set with enable bit 3 on, or bank-0-full was set with enable bit 4 on. Bits 3 and 4 of an accepted write load these enables.
- R8: A write is accepted when wr_i is 1 and busy_o is 0. busy_o rises at the next clock and falls only after the USB side has applied the write. An ordinary update keeps busy high for at least 1 USB clock plus 1 peripheral clock. A transmit-ready set or a bank release keeps it high for at least 3 USB clocks plus 5 peripheral clocks.
- R9: A write presented while busy_o is 1 has no effect on any flag, bit or enable.
- R10: An accepted write with 1 in bit 2 sets txpktrdy_o at the next clock and sets u_txpktrdy_o before busy_o falls. A 0 in bit 2 has no effect.
- R11: Clearing a set bank-0-full flag clears u_bk0_full_o before busy_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| uclk_i | input | 1 | USB clock |
| rst_ni | input | 1 | Asynchronous reset for both domains, active low |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 5 | Write data: 0 transmit-done, 1 bank-0-full, 2 transmit-ready, 3 transmit interrupt enable, 4 receive interrupt enable |
| txcomp_o | output | 1 | Transmit-done flag |
| rxbk0_o | output | 1 | Bank-0-full flag |
| txpktrdy_o | output | 1 | Transmit-ready bit, firmware view |
| rxcnt_o | output | CNT_W | Received byte count, 0 while the bank is empty |
| irq_o | output | 1 | Endpoint interrupt, active high, registered |
| busy_o | output | 1 | Cross-domain update in progress |
| u_txack_i | input | 1 | USB domain: host acknowledged the IN packet |
| u_rxpkt_i | input | 1 | USB domain: packet stored in bank 0 |
| u_rxcnt_i | input | CNT_W | USB domain: byte count that goes with u_rxpkt_i |
| u_txpktrdy_o | output | 1 | USB domain: IN data is ready to send |
| u_bk0_full_o | output | 1 | USB domain: bank 0 is owned by firmware |

## Verification
Flag clears, the transmit-ready set and the write-one cases are due at the negative edge right after the accepting clock, and the bench samples them there. USB-side state changes one USB clock after the event pulse. Events that cross into the peripheral domain arrive within a bounded window, so the bench allows 8 peripheral clocks for them. The interrupt is due one clock after its sources, and a reference model compares it on every peripheral clock, sampled 1 ns after the falling edge. Busy is counted in peripheral clocks from the clock after the write. The count is checked against the stated minimums at a 2:1 clock ratio (3 cycles ordinary, 11 cycles buffer hand-off), and the USB-side state is checked at the first sample where busy is low. For the set-wins case the bench first measures the event latency, then replays the same event phase with the clearing write aimed at that exact clock.

// File: rtl/usb_ep_csr_pkg.sv
package usb_ep_csr_pkg;
  localparam int WD_W     = 5;
  localparam int TXC_B    = 0;
  localparam int RXB_B    = 1;
  localparam int PKT_B    = 2;
  localparam int IE_TX_B  = 3;
  localparam int IE_RX_B  = 4;

  typedef struct packed {
    logic set_pktrdy;
    logic release_bk0;
  } xreq_t;
endpackage

// File: rtl/ep_tgl_sync.sv
module ep_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], tgl_i};
  end

  assign pulse_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/ep_usb_side.sv
module ep_usb_side
  import usb_ep_csr_pkg::*;
#(
  parameter int CNT_W        = 7,
  parameter int SYNC_STAGES  = 2,
  parameter int U_WAIT_LIGHT = 1,
  parameter int U_WAIT_HEAVY = 3
) (
  input  logic             uclk_i,
  input  logic             rst_ni,
  input  logic             req_tgl_i,
  input  xreq_t            req_i,
  input  logic             txack_i,
  input  logic             rxpkt_i,
  input  logic [CNT_W-1:0] rxcnt_i,
  output logic             ack_tgl_o,
  output logic             tx_tgl_o,
  output logic             rx_tgl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             txpktrdy_o,
  output logic             bk0_full_o
);
  localparam int WMAX = (U_WAIT_HEAVY > U_WAIT_LIGHT) ? U_WAIT_HEAVY : U_WAIT_LIGHT;
  localparam int WC_W = $clog2(WMAX + 1);

  logic            req_evt;
  logic            waiting_q;
  logic [WC_W-1:0] wait_q;

  ep_tgl_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk_i  (uclk_i),
    .rst_ni (rst_ni),
    .tgl_i  (req_tgl_i),
    .pulse_o(req_evt)
  );

  // handshake: apply on arrival, then hold the ack back for the flag's wait
  always_ff @(posedge uclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q <= 1'b0;
      wait_q    <= '0;
      ack_tgl_o <= 1'b0;
    end else if (req_evt) begin
      waiting_q <= 1'b1;
      wait_q    <= (req_i.set_pktrdy | req_i.release_bk0) ?
                   WC_W'(U_WAIT_HEAVY - 1) : WC_W'(U_WAIT_LIGHT - 1);
    end else if (waiting_q) begin
      if (wait_q == '0) begin
        waiting_q <= 1'b0;
        ack_tgl_o <= ~ack_tgl_o;
      end else begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  always_ff @(posedge uclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txpktrdy_o <= 1'b0;
      bk0_full_o <= 1'b0;
      tx_tgl_o   <= 1'b0;
      rx_tgl_o   <= 1'b0;
      cnt_o      <= '0;
    end else begin
      if (req_evt && req_i.set_pktrdy)  txpktrdy_o <= 1'b1;
      if (req_evt && req_i.release_bk0) bk0_full_o <= 1'b0;
      if (txack_i) begin
        txpktrdy_o <= 1'b0;
        tx_tgl_o   <= ~tx_tgl_o;
      end
      if (rxpkt_i) begin
        bk0_full_o <= 1'b1;
        cnt_o      <= rxcnt_i;
        rx_tgl_o   <= ~rx_tgl_o;
      end
    end
  end
endmodule

// File: rtl/usb_ep_csr.sv
module usb_ep_csr
  import usb_ep_csr_pkg::*;
#(
  parameter int CNT_W        = 7,
  parameter int SYNC_STAGES  = 2,
  parameter int P_MIN_LIGHT  = 1,
  parameter int P_MIN_HEAVY  = 5,
  parameter int U_WAIT_LIGHT = 1,
  parameter int U_WAIT_HEAVY = 3
) (
  input  logic             clk_i,
  input  logic             uclk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WD_W-1:0]  wdata_i,
  output logic             txcomp_o,
  output logic             rxbk0_o,
  output logic             txpktrdy_o,
  output logic [CNT_W-1:0] rxcnt_o,
  output logic             irq_o,
  output logic             busy_o,
  input  logic             u_txack_i,
  input  logic             u_rxpkt_i,
  input  logic [CNT_W-1:0] u_rxcnt_i,
  output logic             u_txpktrdy_o,
  output logic             u_bk0_full_o
);
  localparam int NSYNC = 3;
  localparam int PMAX  = (P_MIN_HEAVY > P_MIN_LIGHT) ? P_MIN_HEAVY : P_MIN_LIGHT;
  localparam int PC_W  = $clog2(PMAX + 1) + 1;

  logic             u_ack_tgl, u_tx_tgl, u_rx_tgl;
  logic [CNT_W-1:0] u_cnt;
  logic [NSYNC-1:0] tgl_u, evt;
  logic             ack_evt, tx_evt, rx_evt;

  logic             busy_q, ack_seen_q, heavy_q, req_tgl_q;
  logic [PC_W-1:0]  pcnt_q;
  xreq_t            pay_q;
  logic             tx_q, rx_q, pr_q, irq_q;
  logic [1:0]       ie_q;
  logic [CNT_W-1:0] cnt_q;

  logic accept, rel, setp, done;

  ep_usb_side #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES),
    .U_WAIT_LIGHT(U_WAIT_LIGHT),
    .U_WAIT_HEAVY(U_WAIT_HEAVY)
  ) i_usb (
    .uclk_i    (uclk_i),
    .rst_ni    (rst_ni),
    .req_tgl_i (req_tgl_q),
    .req_i     (pay_q),
    .txack_i   (u_txack_i),
    .rxpkt_i   (u_rxpkt_i),
    .rxcnt_i   (u_rxcnt_i),
    .ack_tgl_o (u_ack_tgl),
    .tx_tgl_o  (u_tx_tgl),
    .rx_tgl_o  (u_rx_tgl),
    .cnt_o     (u_cnt),
    .txpktrdy_o(u_txpktrdy_o),
    .bk0_full_o(u_bk0_full_o)
  );

  assign tgl_u = {u_rx_tgl, u_tx_tgl, u_ack_tgl};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    ep_tgl_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tgl_i  (tgl_u[g]),
      .pulse_o(evt[g])
    );
  end

  assign ack_evt = evt[0];
  assign tx_evt  = evt[1];
  assign rx_evt  = evt[2];

  assign accept = wr_i & ~busy_q;
  // release only a bank that firmware really holds and that is not being refilled
  assign rel    = accept & ~wdata_i[RXB_B] & rx_q & ~rx_evt;
  assign setp   = accept & wdata_i[PKT_B];
  assign done   = (ack_seen_q | ack_evt) &&
                  (int'(pcnt_q) >= (heavy_q ? P_MIN_HEAVY : P_MIN_LIGHT) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      ack_seen_q <= 1'b0;
      heavy_q    <= 1'b0;
      req_tgl_q  <= 1'b0;
      pcnt_q     <= '0;
      pay_q      <= '0;
    end else if (accept) begin
      busy_q     <= 1'b1;
      ack_seen_q <= 1'b0;
      heavy_q    <= rel | setp;
      req_tgl_q  <= ~req_tgl_q;
      pcnt_q     <= '0;
      pay_q      <= '{set_pktrdy: setp, release_bk0: rel};
    end else if (busy_q) begin
      if (ack_evt)        ack_seen_q <= 1'b1;
      if (pcnt_q != '1)   pcnt_q     <= pcnt_q + 1'b1;
      if (done)           busy_q     <= 1'b0;
    end
  end

  // USB-side sets take priority over firmware clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
      pr_q  <= 1'b0;
      ie_q  <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (tx_evt)                              tx_q <= 1'b1;
      else if (accept && !wdata_i[TXC_B])      tx_q <= 1'b0;
      if (rx_evt) begin
        rx_q  <= 1'b1;
        cnt_q <= u_cnt;
      end else if (accept && !wdata_i[RXB_B])  rx_q <= 1'b0;
      if (setp)                                pr_q <= 1'b1;
      else if (tx_evt)                         pr_q <= 1'b0;
      if (accept) ie_q <= {wdata_i[IE_RX_B], wdata_i[IE_TX_B]};
      irq_q <= (tx_q & ie_q[0]) | (rx_q & ie_q[1]);
    end
  end

  assign txcomp_o   = tx_q;
  assign rxbk0_o    = rx_q;
  assign txpktrdy_o = pr_q;
  assign rxcnt_o    = rx_q ? cnt_q : '0;
  assign irq_o      = irq_q;
  assign busy_o     = busy_q;
endmodule

// File: rtl/usb_ep_csr_chk.sv
module usb_ep_csr_chk #(
  parameter int P_MIN_LIGHT = 1,
  parameter int P_MIN_HEAVY = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic wr_txc_i,
  input logic wr_pkt_i,
  input logic busy_o,
  input logic txcomp_o,
  input logic rxbk0_o,
  input logic irq_o
);
  logic [7:0] bcnt_q;
  logic       heavy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q  <= '0;
      heavy_q <= 1'b0;
    end else if (wr_i && !busy_o) begin
      bcnt_q  <= '0;
      heavy_q <= wr_pkt_i;
    end else if (busy_o && bcnt_q != 8'hff) begin
      bcnt_q  <= bcnt_q + 1'b1;
    end
  end

  a_r8_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o) |=> busy_o);

  a_r8_busy_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (int'(bcnt_q) >= (heavy_q ? P_MIN_HEAVY : P_MIN_LIGHT)));

  a_r7_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(txcomp_o || rxbk0_o));

  a_r3_keep_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o && wr_txc_i && txcomp_o) |=> txcomp_o);

  a_r9_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_o && txcomp_o) |=> txcomp_o);
endmodule

bind usb_ep_csr usb_ep_csr_chk #(
  .P_MIN_LIGHT(P_MIN_LIGHT),
  .P_MIN_HEAVY(P_MIN_HEAVY)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .wr_txc_i(wdata_i[usb_ep_csr_pkg::TXC_B]),
  .wr_pkt_i(wdata_i[usb_ep_csr_pkg::PKT_B]),
  .busy_o  (busy_o),
  .txcomp_o(txcomp_o),
  .rxbk0_o (rxbk0_o),
  .irq_o   (irq_o)
);

// File: tb/test_usb_ep_csr.sv
`timescale 1ns/1ps
module test_usb_ep_csr;
  localparam int CNT_W = 7;

  logic             clk_i = 1'b0, uclk_i = 1'b0, rst_ni = 1'b0;
  logic             wr_i = 1'b0;
  logic [4:0]       wdata_i = '0;
  logic             txcomp_o, rxbk0_o, txpktrdy_o, irq_o, busy_o;
  logic [CNT_W-1:0] rxcnt_o;
  logic             u_txack_i = 1'b0, u_rxpkt_i = 1'b0;
  logic [CNT_W-1:0] u_rxcnt_i = '0;
  logic             u_txpktrdy_o, u_bk0_full_o;

  int  vectors = 0, miscompares = 0;
  bit  finished = 1'b0;
  bit  mon_on = 1'b0;

  // bits: 4 ie_rx, 3 ie_tx, 2 pktrdy, 1 bank, 0 txdone
  localparam logic [4:0] KEEP    = 5'h1B;
  localparam logic [4:0] CLR_TX  = 5'h1A;
  localparam logic [4:0] REL_RX  = 5'h19;
  localparam logic [4:0] SET_PKT = 5'h1F;
  localparam logic [4:0] IE_OFF  = 5'h03;

  always #2.5 clk_i = ~clk_i;
  initial begin
    #1.25;
    forever #5 uclk_i = ~uclk_i;
  end

  usb_ep_csr i_usb_ep_csr (
    .clk_i, .uclk_i, .rst_ni, .wr_i, .wdata_i,
    .txcomp_o, .rxbk0_o, .txpktrdy_o, .rxcnt_o, .irq_o, .busy_o,
    .u_txack_i, .u_rxpkt_i, .u_rxcnt_i, .u_txpktrdy_o, .u_bk0_full_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model for the interrupt (R7), compared every clock
  logic [1:0] ie_m = '0, ie_pend = '0;
  bit         pend = 1'b0, irq_exp = 1'b0;
  always @(negedge clk_i) begin
    #1;
    if (mon_on) begin
      chk(irq_o === irq_exp, "R7 irq model", int'(irq_o), int'(irq_exp));
      if (pend) ie_m = ie_pend;
      irq_exp = (txcomp_o & ie_m[0]) | (rxbk0_o & ie_m[1]);
      pend    = wr_i && !busy_o;
      ie_pend = {wdata_i[4], wdata_i[3]};
    end
  end

  bit         s_tx, s_rx, s_pr;
  int         s_cnt;
  int         blen;

  task automatic do_wr(input logic [4:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
    s_tx = txcomp_o; s_rx = rxbk0_o; s_pr = txpktrdy_o; s_cnt = int'(rxcnt_o);
    blen = 0;
    while (busy_o && blen < 100) begin
      blen++;
      @(negedge clk_i);
    end
  endtask

  task automatic tx_event(output int n);
    @(negedge uclk_i);
    fork
      begin
        u_txack_i = 1'b1;
        @(negedge uclk_i);
        u_txack_i = 1'b0;
      end
      begin
        n = 0;
        do begin
          @(negedge clk_i);
          n++;
        end while (!txcomp_o && n < 20);
      end
    join
  endtask

  initial begin
    int lat, lat2;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk({txcomp_o, rxbk0_o, txpktrdy_o, irq_o, busy_o, u_txpktrdy_o, u_bk0_full_o} == '0 &&
        rxcnt_o == '0, "R1 reset outputs", 0, 0);
    rst_ni = 1'b1;
    mon_on = 1'b1;

    // enables on, ordinary update
    do_wr(KEEP);
    chk(blen >= 3, "R8 light busy min", blen, 3);
    chk(blen <= 40, "R8 busy ends", blen, 40);

    // host ack sets transmit-done
    tx_event(lat);
    chk(lat <= 8, "R4 txdone latency", lat, 8);
    chk(txcomp_o == 1'b1, "R4 txdone set", int'(txcomp_o), 1);
    repeat (2) @(negedge clk_i);
    chk(irq_o == 1'b1, "R7 irq on tx", int'(irq_o), 1);

    do_wr(KEEP);
    chk(s_tx == 1'b1, "R3 write one keeps txdone", int'(s_tx), 1);
    do_wr(CLR_TX);
    chk(s_tx == 1'b0, "R2 write zero clears txdone", int'(s_tx), 0);

    // packet into bank 0
    @(negedge uclk_i);
    u_rxpkt_i = 1'b1; u_rxcnt_i = 7'd37;
    @(negedge uclk_i);
    u_rxpkt_i = 1'b0; u_rxcnt_i = '0;
    chk(u_bk0_full_o == 1'b1, "R5 usb bank full", int'(u_bk0_full_o), 1);
    repeat (8) @(negedge clk_i);
    chk(rxbk0_o == 1'b1, "R5 bank flag set", int'(rxbk0_o), 1);
    chk(int'(rxcnt_o) == 37, "R5 byte count", int'(rxcnt_o), 37);

    do_wr(KEEP);
    chk(s_rx == 1'b1, "R3 write one keeps bank flag", int'(s_rx), 1);
    do_wr(REL_RX);
    chk(s_rx == 1'b0, "R2 write zero releases bank", int'(s_rx), 0);
    chk(s_cnt == 0, "R5 count zero when empty", s_cnt, 0);
    chk(blen >= 11, "R8 heavy busy min release", blen, 11);
    chk(u_bk0_full_o == 1'b0, "R11 usb bank released", int'(u_bk0_full_o), 0);

    // transmit ready
    do_wr(SET_PKT);
    chk(s_pr == 1'b1, "R10 pktrdy set", int'(s_pr), 1);
    chk(blen >= 11, "R8 heavy busy min pktrdy", blen, 11);
    chk(u_txpktrdy_o == 1'b1, "R10 usb pktrdy seen", int'(u_txpktrdy_o), 1);
    do_wr(KEEP);
    chk(s_pr == 1'b1, "R10 zero has no effect", int'(s_pr), 1);
    tx_event(lat);
    chk(u_txpktrdy_o == 1'b0, "R4 usb pktrdy cleared", int'(u_txpktrdy_o), 0);
    chk(txcomp_o == 1'b1 && txpktrdy_o == 1'b0, "R4 pktrdy cleared on ack",
        int'(txpktrdy_o), 0);

    // enables off
    do_wr(IE_OFF);
    repeat (2) @(negedge clk_i);
    chk(irq_o == 1'b0, "R7 irq masked", int'(irq_o), 0);
    do_wr(KEEP);
    repeat (2) @(negedge clk_i);
    chk(irq_o == 1'b1, "R7 irq unmasked", int'(irq_o), 1);

    // write during busy ignored
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = KEEP;
    @(negedge clk_i);
    wdata_i = 5'h02;
    @(negedge clk_i);
    wr_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    chk(txcomp_o == 1'b1, "R9 busy write ignored txdone", int'(txcomp_o), 1);
    chk(txpktrdy_o == 1'b0, "R9 busy write ignored pktrdy", int'(txpktrdy_o), 0);
    repeat (2) @(negedge clk_i);
    chk(irq_o == 1'b1, "R9 busy write ignored enables", int'(irq_o), 1);

    // set wins over coincident clear
    do_wr(CLR_TX);
    tx_event(lat);
    do_wr(CLR_TX);
    chk(txcomp_o == 1'b0, "R2 cleared before race", int'(txcomp_o), 0);
    @(negedge uclk_i);
    fork
      begin
        u_txack_i = 1'b1;
        @(negedge uclk_i);
        u_txack_i = 1'b0;
      end
      begin
        repeat (lat - 1) @(negedge clk_i);
        wr_i = 1'b1; wdata_i = CLR_TX;
        @(negedge clk_i);
        wr_i = 1'b0;
        lat2 = int'(txcomp_o);
      end
    join
    chk(lat2 == 1, "R6 set wins over clear", lat2, 1);
    while (busy_o) @(negedge clk_i);
    chk(txcomp_o == 1'b1, "R6 flag still set", int'(txcomp_o), 1);

    repeat (4) @(negedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule